// File: doc/BRIEF.md
# Backplane Interrupt Requester with Broadcast Pulse

This block raises prioritized interrupt requests on a seven-level backplane. Software writes a nonzero level into the control register. The block then pulls the matching active-low request line low and holds it there until the bus runs an interrupt-acknowledge cycle at that level. In that cycle the block answers with the programmed 8-bit status/ID vector for one clock, and the request drops. A write to the clear bit withdraws a request that was never acknowledged. This clear exists to recover from errors.

A second path generates a broadcast pulse of `PULSE_W` clock cycles on request line 1 or on request line 2. A function field chooses what request line 2 carries:
- normal interrupt use,
- a programmable clock,
- the pulse generator output,
- a slow clock with a half period of `SLOW_HALF` cycles (about one second per period by default).

The request path is a three-state machine. `RQ_IDLE` goes to `RQ_ASSERTED` on an accepted level write. `RQ_ASSERTED` goes to `RQ_RESPOND` on a matching acknowledge, and back to `RQ_IDLE` on a clear. `RQ_RESPOND` always returns to `RQ_IDLE` after one cycle. The pulse path is a two-state machine. `PG_IDLE` goes to `PG_ACTIVE` on an accepted start. `PG_ACTIVE` returns to `PG_IDLE` when its cycle counter expires.

Top module: `bkpl_interrupter`

## Requirements
- R1: After reset every request line is high (7'h7F), `vec_valid` is 0, and all registers read zero. Function code 00 (normal) is selected and broadcast is disabled.
- R2: A control write (address 0) with clear bit 3 at 0 and a nonzero level L in bits [2:0], made while nothing is pending, drives `irq_n[L-1]` low from the next cycle. It drives only that line. Level 0 raises nothing, and bits [2:0] always read 0.
- R3: While a request is pending, control bit 10 reads 1 and bits [13:11] read its level. Otherwise both read 0.
- R4: When `iack_valid` is high with `iack_level` equal to the pending level, the next cycle behaves as follows: `vec_valid` is high for exactly one cycle, `vec_data` equals the vector register (address 1, bits [7:0]) as it was at the acknowledge, the line is released, and pending reads 0. An acknowledge at any other level changes nothing.
- R5: A level write while a request is pending, or in the respond cycle, is ignored.
- R6: A control write with bit 3 set withdraws a pending request from the next cycle. Bit 3 reads 0. In the same cycle, a clear wins over an acknowledge, so no vector is returned.
- R7: A control write with bit 5 (enable) and bit 4 (start) both set starts a pulse. The pulse runs from the next cycle for `PULSE_W` cycles, on line 1 if bit 8 is 0 and on line 2 if bit 8 is 1. The target line is latched at the start. Busy bit 9 reads 1 during the pulse, and bit 4 always reads 0.
- R8: A start while busy, or a start with bit 5 at 0, has no effect.
- R9: Control bits [7:6] select what line 2 carries. 00 is the level-2 request or a pulse aimed at line 2. 01 is a clock with a half period of (divider register, address 2) + 1 cycles. 10 is any active pulse. 11 is a clock with a half period of `SLOW_HALF` cycles. A clock pulls the line low in its high phase.
- R10: The vector register, the divider register, and control bits 5, [7:6] and 8 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 vector, 2 divider) |
| reg_wdata | input | 16 | Register write data |
| rd_data | output | 16 | Read data for `reg_addr`, combinational |
| iack_valid | input | 1 | Interrupt-acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector response strobe |
| vec_data | output | 8 | Returned status/ID vector |
| irq_n | output | 7 | Active-low request lines; bit i is level i+1 |

## Verification
The assertions assume that `iack_valid` is a single-cycle strobe and that its level is stable while it is high. They also assume that register writes never change `reg_addr` in the middle of a cycle. The stimulus drives every input shortly after a rising edge and holds it for whole cycles. Each acknowledge lasts exactly one cycle. Clears and acknowledges are made simultaneous only on purpose, to exercise the R6 priority.

// File: rtl/bkpl_irq_pkg.sv
package bkpl_irq_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE     = 2'd0,
        RQ_ASSERTED = 2'd1,
        RQ_RESPOND  = 2'd2
    } req_state_e;

    typedef enum logic {
        PG_IDLE   = 1'b0,
        PG_ACTIVE = 1'b1
    } pulse_state_e;

    typedef enum logic [1:0] {
        L2_NORMAL  = 2'b00,
        L2_PROGCLK = 2'b01,
        L2_PULSE   = 2'b10,
        L2_SLOWCLK = 2'b11
    } line2_func_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_VEC  = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    localparam int unsigned CB_LVL   = 0;
    localparam int unsigned CB_CLR   = 3;
    localparam int unsigned CB_START = 4;
    localparam int unsigned CB_EN    = 5;
    localparam int unsigned CB_FUNC  = 6;
    localparam int unsigned CB_SEL   = 8;
    localparam int unsigned CB_BUSY  = 9;
    localparam int unsigned CB_PEND  = 10;
    localparam int unsigned CB_LSTAT = 11;

endpackage

// File: rtl/irq_request_fsm.sv
module irq_request_fsm
    import bkpl_irq_pkg::*;
#(
    parameter int unsigned LVL_W = 3,
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_req,
    input  logic [LVL_W-1:0] raise_lvl,
    input  logic             clear_req,
    input  logic             iack_valid,
    input  logic [LVL_W-1:0] iack_level,
    input  logic [VEC_W-1:0] vector_in,
    output logic             pending,
    output logic [LVL_W-1:0] pend_lvl,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_data
);

    req_state_e       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] resp_q;
    logic             take;
    logic             ack_hit;

    assign take    = (state_q == RQ_IDLE) && raise_req && !clear_req && (raise_lvl != '0);
    assign ack_hit = (state_q == RQ_ASSERTED) && iack_valid && !clear_req && (iack_level == lvl_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: begin
                if (take) state_d = RQ_ASSERTED;
            end
            RQ_ASSERTED: begin
                if (clear_req)    state_d = RQ_IDLE;
                else if (ack_hit) state_d = RQ_RESPOND;
            end
            RQ_RESPOND: state_d = RQ_IDLE;
            default:    state_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            resp_q <= '0;
        end else begin
            if (take)    lvl_q  <= raise_lvl;
            if (ack_hit) resp_q <= vector_in;
        end
    end

    always_comb begin
        pending   = (state_q == RQ_ASSERTED);
        pend_lvl  = pending ? lvl_q : '0;
        vec_valid = (state_q == RQ_RESPOND);
        vec_data  = vec_valid ? resp_q : '0;
    end

endmodule

// File: rtl/bcast_pulse_gen.sv
module bcast_pulse_gen
    import bkpl_irq_pkg::*;
#(
    parameter int unsigned PULSE_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic to_line2,
    output logic busy,
    output logic on_line1,
    output logic on_line2
);

    localparam int unsigned CNT_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_W - 1);

    pulse_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             sel2_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE:   if (start) state_d = PG_ACTIVE;
            PG_ACTIVE: if (cnt_q == '0) state_d = PG_IDLE;
            default:   state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sel2_q <= 1'b0;
        end else if (state_q == PG_IDLE) begin
            if (start) begin
                cnt_q  <= CNT_LOAD;
                sel2_q <= to_line2;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy     = (state_q == PG_ACTIVE);
        on_line1 = busy && !sel2_q;
        on_line2 = busy && sel2_q;
    end

endmodule

// File: rtl/phase_divider.sv
module phase_divider #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit,
    output logic             phase
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bkpl_interrupter.sv
module bkpl_interrupter
    import bkpl_irq_pkg::*;
#(
    parameter int unsigned LEVELS    = 7,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned PULSE_W   = 16,
    parameter int unsigned SLOW_HALF = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       rd_data,
    input  logic              iack_valid,
    input  logic [2:0]        iack_level,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_data,
    output logic [LEVELS-1:0] irq_n
);

    localparam int unsigned LVL_W  = $clog2(LEVELS + 1);
    localparam int unsigned SLOW_W = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
    localparam logic [SLOW_W-1:0] SLOW_LIMIT = SLOW_W'(SLOW_HALF - 1);

    logic              bc_en_q, sel_q;
    line2_func_e       func_q;
    logic [VEC_W-1:0]  vec_q;
    logic [DIV_W-1:0]  div_q;

    logic              ctrl_wr;
    logic              pend_flag;
    logic [LVL_W-1:0]  pend_lvl;
    logic              pulse_busy, p_line1, p_line2;
    logic              pclk_phase, slow_phase;
    logic [LEVELS-1:0] lvl_line, line_on;
    logic              line2_on;

    assign ctrl_wr = wr_en && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_en_q <= 1'b0;
            sel_q   <= 1'b0;
            func_q  <= L2_NORMAL;
            vec_q   <= '0;
            div_q   <= '0;
        end else if (wr_en) begin
            unique case (reg_addr)
                ADDR_CTRL: begin
                    bc_en_q <= reg_wdata[CB_EN];
                    sel_q   <= reg_wdata[CB_SEL];
                    func_q  <= line2_func_e'(reg_wdata[CB_FUNC +: 2]);
                end
                ADDR_VEC: vec_q <= reg_wdata[VEC_W-1:0];
                ADDR_DIV: div_q <= reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    irq_request_fsm #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_req  (ctrl_wr),
        .raise_lvl  (reg_wdata[CB_LVL +: LVL_W]),
        .clear_req  (ctrl_wr && reg_wdata[CB_CLR]),
        .iack_valid (iack_valid),
        .iack_level (iack_level[LVL_W-1:0]),
        .vector_in  (vec_q),
        .pending    (pend_flag),
        .pend_lvl   (pend_lvl),
        .vec_valid  (vec_valid),
        .vec_data   (vec_data)
    );

    bcast_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ctrl_wr && reg_wdata[CB_START] && reg_wdata[CB_EN]),
        .to_line2 (reg_wdata[CB_SEL]),
        .busy     (pulse_busy),
        .on_line1 (p_line1),
        .on_line2 (p_line2)
    );

    phase_divider #(.CNT_W(DIV_W)) u_progclk (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (div_q),
        .phase (pclk_phase)
    );

    phase_divider #(.CNT_W(SLOW_W)) u_slowclk (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (SLOW_LIMIT),
        .phase (slow_phase)
    );

    always_comb begin
        unique case (func_q)
            L2_NORMAL:  line2_on = lvl_line[1] || p_line2;
            L2_PROGCLK: line2_on = pclk_phase;
            L2_PULSE:   line2_on = pulse_busy;
            L2_SLOWCLK: line2_on = slow_phase;
            default:    line2_on = 1'b0;
        endcase
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_line
        assign lvl_line[g] = pend_flag && (pend_lvl == LVL_W'(g + 1));
        if (g == 0) begin : g_l1
            assign line_on[g] = lvl_line[g] || p_line1;
        end else if (g == 1) begin : g_l2
            assign line_on[g] = line2_on;
        end else begin : g_ln
            assign line_on[g] = lvl_line[g];
        end
        assign irq_n[g] = ~line_on[g];
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                rd_data[CB_EN]          = bc_en_q;
                rd_data[CB_FUNC +: 2]   = func_q;
                rd_data[CB_SEL]         = sel_q;
                rd_data[CB_BUSY]        = pulse_busy;
                rd_data[CB_PEND]        = pend_flag;
                rd_data[CB_LSTAT +: 3]  = 3'(pend_lvl);
            end
            ADDR_VEC: rd_data[VEC_W-1:0] = vec_q;
            ADDR_DIV: rd_data[DIV_W-1:0] = div_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/bkpl_interrupter_chk.sv
module bkpl_interrupter_chk #(
    parameter int unsigned LEVELS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        reg_addr,
    input logic [15:0]       reg_wdata,
    input logic              iack_valid,
    input logic              vec_valid,
    input logic [LEVELS-1:0] irq_n,
    input logic              pend_flag,
    input logic              pulse_busy,
    input logic [15:0]       rd_data
);

    // R2
    upper_lines_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n[LEVELS-1:2]));

    // R4
    vec_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R4
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(iack_valid));

    // R6
    clear_withdraws_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd0 && reg_wdata[3]) |=> !pend_flag);

    // R7
    pulse_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_busy) |-> $past(wr_en));

    // R3
    pending_level_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flag && reg_addr == 2'd0) |-> (rd_data[13:11] != 3'd0));

endmodule

bind bkpl_interrupter bkpl_interrupter_chk #(.LEVELS(LEVELS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .iack_valid (iack_valid),
    .vec_valid  (vec_valid),
    .irq_n      (irq_n),
    .pend_flag  (pend_flag),
    .pulse_busy (pulse_busy),
    .rd_data    (rd_data)
);

// File: tb/bkpl_interrupter_test.sv
module bkpl_interrupter_test;

    localparam int PW    = 5;
    localparam int SLOWH = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] rd_data;
    logic        iack_valid = 0;
    logic [2:0]  iack_level = 0;
    logic        vec_valid;
    logic [7:0]  vec_data;
    logic [6:0]  irq_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bkpl_interrupter #(.PULSE_W(PW), .SLOW_HALF(SLOWH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .iack_valid(iack_valid),
        .iack_level(iack_level), .vec_valid(vec_valid), .vec_data(vec_data),
        .irq_n(irq_n)
    );

    // behavioural reference model
    bit m_pend, m_resp, m_en, m_sel, m_pl2, m_pc_ph, m_sl_ph;
    int m_lvl, m_rvec, m_vec, m_div, m_func, m_pbusy, m_pc_cnt, m_sl_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_resp = 0; m_en = 0; m_sel = 0; m_pl2 = 0;
            m_pc_ph = 0; m_sl_ph = 0; m_lvl = 0; m_rvec = 0; m_vec = 0;
            m_div = 0; m_func = 0; m_pbusy = 0; m_pc_cnt = 0; m_sl_cnt = 0;
        end else begin
            bit cw, clr, nresp;
            cw = wr_en && reg_addr == 0;
            clr = cw && reg_wdata[3];
            nresp = 0;
            if (m_pend) begin
                if (clr) m_pend = 0;
                else if (iack_valid && iack_level == m_lvl) begin
                    m_pend = 0; nresp = 1; m_rvec = m_vec;
                end
            end else if (!m_resp && cw && !clr && reg_wdata[2:0] != 0) begin
                m_pend = 1; m_lvl = reg_wdata[2:0];
            end
            m_resp = nresp;
            if (m_pbusy > 0) m_pbusy--;
            else if (cw && reg_wdata[4] && reg_wdata[5]) begin
                m_pbusy = PW; m_pl2 = reg_wdata[8];
            end
            if (m_pc_cnt >= m_div) begin m_pc_cnt = 0; m_pc_ph = !m_pc_ph; end
            else m_pc_cnt++;
            if (m_sl_cnt >= SLOWH - 1) begin m_sl_cnt = 0; m_sl_ph = !m_sl_ph; end
            else m_sl_cnt++;
            if (wr_en) begin
                if (reg_addr == 0) begin
                    m_en = reg_wdata[5]; m_func = reg_wdata[7:6]; m_sel = reg_wdata[8];
                end
                if (reg_addr == 1) m_vec = reg_wdata[7:0];
                if (reg_addr == 2) m_div = reg_wdata;
            end
        end
    end

    function automatic logic [6:0] exp_irq();
        logic [6:0] on;
        bit l2;
        on = 0;
        for (int i = 1; i <= 7; i++) on[i-1] = m_pend && m_lvl == i;
        on[0] = on[0] || (m_pbusy > 0 && !m_pl2);
        case (m_func)
            0: l2 = on[1] || (m_pbusy > 0 && m_pl2);
            1: l2 = m_pc_ph;
            2: l2 = m_pbusy > 0;
            default: l2 = m_sl_ph;
        endcase
        on[1] = l2;
        return ~on;
    endfunction

    function automatic logic [15:0] exp_rd(logic [1:0] a);
        logic [15:0] r;
        r = 0;
        if (a == 0) begin
            r[5] = m_en; r[7:6] = m_func; r[8] = m_sel; r[9] = m_pbusy > 0;
            r[10] = m_pend; r[13:11] = m_pend ? m_lvl : 0;
        end else if (a == 1) r[7:0] = m_vec;
        else if (a == 2) r = m_div;
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 R7 R9 request lines", irq_n, exp_irq());
            check("R4 vector strobe", {vec_valid, vec_data}, {m_resp, m_resp ? 8'(m_rvec) : 8'h00});
            check("R10 read data", rd_data, exp_rd(reg_addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual %0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        wr_en = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    task automatic ack(logic [2:0] l);
        @(posedge clk); #1;
        iack_valid = 1; iack_level = l;
        @(posedge clk); #1;
        iack_valid = 0; iack_level = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        check("R1 lines after reset", irq_n, 7'h7F);
        check("R1 vec_valid after reset", vec_valid, 0);
        check("R1 control after reset", rd_data, 16'h0000);

        wr(1, 16'h00A5);
        wr(2, 16'h0003);
        reg_addr = 1; #1;
        check("R10 vector readback", rd_data, 16'h00A5);
        reg_addr = 2; #1;
        check("R10 divider readback", rd_data, 16'h0003);
        reg_addr = 0;

        wr(0, 16'h0000);
        check("R2 level zero raises nothing", irq_n, 7'h7F);

        wr(0, 16'h0003);
        check("R2 level 3 line", irq_n, 7'b1111011);
        check("R3 pending and level status", rd_data, 16'h1C00);

        wr(0, 16'h0005);
        check("R5 second level ignored", irq_n, 7'b1111011);
        check("R5 level status unchanged", rd_data[13:11], 3);

        ack(3'd2);
        check("R4 wrong level no vector", vec_valid, 0);
        check("R4 wrong level keeps line", irq_n, 7'b1111011);

        ack(3'd3);
        check("R4 vector strobe", vec_valid, 1);
        check("R4 vector value", vec_data, 8'hA5);
        check("R4 line released", irq_n, 7'h7F);
        check("R4 pending cleared", rd_data[10], 0);
        idle(1);
        check("R4 strobe one cycle", vec_valid, 0);

        wr(0, 16'h0006);
        check("R2 level 6 line", irq_n, 7'b1011111);
        wr(0, 16'h0008);
        check("R6 clear withdraws", irq_n, 7'h7F);
        check("R6 clear reads zero", rd_data[3], 0);

        wr(0, 16'h0007);
        @(posedge clk); #1;
        wr_en = 1; reg_wdata = 16'h0008; iack_valid = 1; iack_level = 7;
        @(posedge clk); #1;
        wr_en = 0; reg_wdata = 0; iack_valid = 0; iack_level = 0;
        check("R6 clear beats ack", vec_valid, 0);
        check("R6 clear beats ack line", irq_n, 7'h7F);

        wr(0, 16'h0010);
        check("R8 start without enable", rd_data[9], 0);

        wr(0, 16'h0030);
        check("R7 pulse on line 1", irq_n, 7'b1111110);
        check("R7 busy and start reads zero", rd_data[9:4], 6'b100010);
        wr(0, 16'h0130);
        check("R8 restart while busy ignored", irq_n, 7'b1111110);
        idle(PW);
        check("R7 pulse ended", rd_data[9], 0);

        wr(0, 16'h0130);
        check("R7 pulse on line 2", irq_n, 7'b1111101);
        idle(PW + 1);

        wr(0, 16'h0040);
        idle(20);
        wr(0, 16'h00C0);
        idle(30);
        wr(0, 16'h00B0);
        check("R9 pulse function line 2", irq_n, 7'b1111100);
        idle(PW + 1);
        wr(0, 16'h0082);
        check("R9 level 2 hidden in pulse function", irq_n, 7'h7F);
        check("R9 level 2 still pending", rd_data[10], 1);
        wr(0, 16'h0000);
        check("R9 normal function shows level 2", irq_n, 7'b1111101);
        ack(3'd2);
        check("R4 level 2 vector", vec_data, 8'hA5);
        idle(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule